// File: doc/BRIEF.md
# Bus-Mapped FPGA Configuration Controller

This block sits on a board-control bus and drives the pins that load a bitstream into slave FPGAs. A backplane access is accepted only when its address-modifier code is the one the card answers to, its write flag is active, and the 5-bit slot field of the local address equals the card's geographic address. The geographic pins are active-low, so their inverted value is what the slot field must match. An accepted write then lands in one of three registers: the board control register, the configuration control register or the configuration data register.

The program pin and the configuration clock are gated by a global enable bit in the board control register. The program pin goes low only when that enable and a program-request bit are both set. A write to the data register produces a single configuration-clock pulse, and only when the enable is on. Each strobe assertion is handled once by a four-state bus-cycle sequencer. An active-low system reset, applied asynchronously, restores every register and output to its power-up value.

Top module: `fpga_cfg_port`

## Requirements
- R1: After reset the outputs are cfg_prog_n = 1, cfg_cs_n = 1, cfg_rw_n = 1, cfg_cclk = 0 and cfg_data = 0. Internally the global enable is 0 and the program request is 1.
- R2: An access is taken only when strobe is high, wr_n is 0, am equals parameter AM_CODE (default 6'b100111) and slot equals ~geo_n. For example, geo_n = 10000 matches slot = 01111. Any other access changes no register and no output.
- R3: Writing sel = 4'b0000 (board control) loads the global enable from wdata bit 3.
- R4: Writing sel = 4'b1010 (configuration control) updates three fields. Bit 3 is chip-select, and cfg_cs_n becomes its inverse. Bit 2 is the program request. Bit 1 is read/write, and cfg_rw_n becomes its inverse. Chip-select and read/write appear on the outputs on the first clock edge after strobe is seen.
- R5: cfg_prog_n is 0 exactly when the global enable and the program request are both 1, and 1 otherwise. It follows a register write one clock later than that write.
- R6: Writing sel = 4'b0110 (configuration data) loads wdata into cfg_data. With the enable set, cfg_cclk is high for exactly one cycle, the IO_1 cycle that starts at the first edge after strobe is seen. With the enable clear, cfg_cclk stays 0.
- R7: A strobe assertion is processed once. Input changes while strobe stays high have no effect, and a new access needs strobe to drop first.
- R8: Driving rst_n low, even in the middle of an access, returns all registers and outputs to their R1 values.
- R9: A taken write whose sel matches none of the three register codes changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Board clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| strobe | input | 1 | Backplane data strobe, active high |
| wr_n | input | 1 | Write flag, 0 means write |
| am | input | 6 | Address-modifier code |
| geo_n | input | 5 | Geographic slot address, active low |
| slot | input | 5 | Slot field of the local address |
| sel | input | 4 | Register-select field of the local address |
| wdata | input | 8 | Local data byte |
| cfg_prog_n | output | 1 | FPGA program pin, active low |
| cfg_cs_n | output | 1 | FPGA chip-select, active low |
| cfg_rw_n | output | 1 | FPGA read/write select |
| cfg_cclk | output | 1 | Configuration clock pulse |
| cfg_data | output | 8 | Configuration data byte |

## Verification
The hardest situation to reach is a strobe held across many cycles while the address and data change underneath it. Only the sequencer stops such a cycle from causing a second write or a second clock pulse. The bench holds strobe high for eight cycles during an enabled data write and changes wdata and sel partway through. It then counts the clock pulses and checks that the first data byte is still in place. A second hard case is reset striking while a data write is still in its early states. The bench drops rst_n two cycles into such an access and checks the power-up values while strobe is still high.

// File: rtl/fpga_cfg_port.sv
module fpga_cfg_port #(
  parameter int            AW      = 5,
  parameter int            SW      = 4,
  parameter int            DW      = 8,
  parameter logic [5:0]    AM_CODE = 6'b100111
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic          wr_n,
  input  logic [5:0]    am,
  input  logic [AW-1:0] geo_n,
  input  logic [AW-1:0] slot,
  input  logic [SW-1:0] sel,
  input  logic [DW-1:0] wdata,
  output logic          cfg_prog_n,
  output logic          cfg_cs_n,
  output logic          cfg_rw_n,
  output logic          cfg_cclk,
  output logic [DW-1:0] cfg_data
);

  localparam logic [SW-1:0] SEL_BOARD = 4'b0000;
  localparam logic [SW-1:0] SEL_CTRL  = 4'b1010;
  localparam logic [SW-1:0] SEL_DATA  = 4'b0110;
  localparam int            EN_BIT    = 3;
  localparam int            CS_BIT    = 3;
  localparam int            PRQ_BIT   = 2;
  localparam int            RW_BIT    = 1;

  typedef enum logic [1:0] {S_IDLE, S_IO1, S_IO2, S_WAIT} seq_t;

  seq_t state;
  logic en_q, preq_q;

  wire hit      = (slot == ~geo_n) && (am == AM_CODE) && !wr_n;
  wire take     = (state == S_IDLE) && strobe && hit;
  wire wr_board = take && (sel == SEL_BOARD);
  wire wr_ctrl  = take && (sel == SEL_CTRL);
  wire wr_data  = take && (sel == SEL_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE:  if (strobe) state <= S_IO1;
        S_IO1:   state <= S_IO2;
        S_IO2:   state <= S_WAIT;
        default: if (!strobe) state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      preq_q   <= 1'b1;
      cfg_cs_n <= 1'b1;
      cfg_rw_n <= 1'b1;
      cfg_data <= '0;
    end else begin
      if (wr_board) en_q <= wdata[EN_BIT];
      if (wr_ctrl) begin
        cfg_cs_n <= ~wdata[CS_BIT];
        preq_q   <= wdata[PRQ_BIT];
        cfg_rw_n <= ~wdata[RW_BIT];
      end
      if (wr_data) cfg_data <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_cclk   <= 1'b0;
      cfg_prog_n <= 1'b1;
    end else begin
      cfg_cclk   <= wr_data && en_q;
      cfg_prog_n <= ~(en_q && preq_q);
    end
  end

  AST_CCLK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_cclk |=> !cfg_cclk); // R6
  AST_CCLK_IN_IO1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_cclk |-> (state == S_IO1)); // R6
  AST_PROG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_prog_n |-> $past(en_q && preq_q)); // R5
  AST_WAIT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && strobe) |=> (state == S_WAIT)); // R7
  AST_FOREIGN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && strobe && !hit) |=>
      ($stable(cfg_cs_n) && $stable(cfg_rw_n) && $stable(cfg_data) && !cfg_cclk)); // R2
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |=> ($stable(cfg_cs_n) && $stable(cfg_rw_n) && $stable(cfg_data))); // R7

endmodule

// File: tb/test_fpga_cfg_port.sv
module test_fpga_cfg_port;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] GEO_N   = 5'b10000;
  localparam logic [4:0] MY_SLOT = 5'b01111;
  localparam logic [5:0] AM_OK   = 6'b100111;

  logic clk = 1'b0, rst_n = 1'b0, strobe = 1'b0, wr_n = 1'b1;
  logic [5:0] am = AM_OK;
  logic [4:0] geo_n = GEO_N, slot = 5'b01110;
  logic [3:0] sel = 4'b0000;
  logic [7:0] wdata = 8'h00;
  logic cfg_prog_n, cfg_cs_n, cfg_rw_n, cfg_cclk;
  logic [7:0] cfg_data;
  int n_chk = 0, n_bad = 0;
  int pulses, first_clk;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpga_cfg_port i_fpga_cfg_port (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wr_n(wr_n), .am(am),
    .geo_n(geo_n), .slot(slot), .sel(sel), .wdata(wdata),
    .cfg_prog_n(cfg_prog_n), .cfg_cs_n(cfg_cs_n), .cfg_rw_n(cfg_rw_n),
    .cfg_cclk(cfg_cclk), .cfg_data(cfg_data)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic access(input logic [4:0] s, input logic [5:0] m, input logic w,
                        input logic [3:0] r, input logic [7:0] d);
    @(negedge clk);
    slot = s; am = m; wr_n = w; sel = r; wdata = d; strobe = 1'b1;
    pulses = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i == 0) first_clk = int'(cfg_cclk);
      if (cfg_cclk) pulses++;
    end
    strobe = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_powerup(input string tag);
    check({tag, " prog_n"}, {7'd0, cfg_prog_n}, 8'd1);
    check({tag, " cs_n"},   {7'd0, cfg_cs_n},   8'd1);
    check({tag, " rw_n"},   {7'd0, cfg_rw_n},   8'd1);
    check({tag, " cclk"},   {7'd0, cfg_cclk},   8'd0);
    check({tag, " data"},   cfg_data,           8'h00);
  endtask

  task automatic t_reset;
    check_powerup("R1 reset");
  endtask

  task automatic t_foreign;
    access(5'b01110, AM_OK, 1'b0, 4'b1010, 8'h0E);
    check("R2 foreign slot cs_n", {7'd0, cfg_cs_n}, 8'd1);
    check("R2 foreign slot rw_n", {7'd0, cfg_rw_n}, 8'd1);
    access(MY_SLOT, 6'b000001, 1'b0, 4'b0110, 8'h55);
    check("R2 bad am data", cfg_data, 8'h00);
    access(MY_SLOT, AM_OK, 1'b1, 4'b1010, 8'h0E);
    check("R2 read cycle cs_n", {7'd0, cfg_cs_n}, 8'd1);
  endtask

  task automatic t_ctrl;
    access(MY_SLOT, AM_OK, 1'b0, 4'b1010, 8'h08);
    check("R4 cs asserted", {7'd0, cfg_cs_n}, 8'd0);
    check("R4 rw idle", {7'd0, cfg_rw_n}, 8'd1);
    access(MY_SLOT, AM_OK, 1'b0, 4'b1010, 8'h0E);
    check("R4 rw asserted", {7'd0, cfg_rw_n}, 8'd0);
    check("R5 prog high without enable", {7'd0, cfg_prog_n}, 8'd1);
  endtask

  task automatic t_data_disabled;
    access(MY_SLOT, AM_OK, 1'b0, 4'b0110, 8'hA5);
    check("R6 data loaded", cfg_data, 8'hA5);
    check("R6 no pulse when disabled", pulses[7:0], 8'd0);
  endtask

  task automatic t_enable;
    @(negedge clk);
    slot = MY_SLOT; am = AM_OK; wr_n = 1'b0; sel = 4'b0000; wdata = 8'h08; strobe = 1'b1;
    @(negedge clk);
    check("R5 prog latency", {7'd0, cfg_prog_n}, 8'd1);
    @(negedge clk);
    check("R3 R5 prog low with enable", {7'd0, cfg_prog_n}, 8'd0);
    repeat (3) @(negedge clk);
    strobe = 1'b0;
    repeat (3) @(negedge clk);
    access(MY_SLOT, AM_OK, 1'b0, 4'b1010, 8'h08);
    check("R5 prog high without request", {7'd0, cfg_prog_n}, 8'd1);
    access(MY_SLOT, AM_OK, 1'b0, 4'b1010, 8'h04);
    check("R5 prog low again", {7'd0, cfg_prog_n}, 8'd0);
    check("R4 cs released", {7'd0, cfg_cs_n}, 8'd1);
  endtask

  task automatic t_data_enabled;
    access(MY_SLOT, AM_OK, 1'b0, 4'b0110, 8'h3C);
    check("R6 data loaded enabled", cfg_data, 8'h3C);
    check("R6 pulse in IO_1", first_clk[7:0], 8'd1);
    check("R6 single pulse", pulses[7:0], 8'd1);
  endtask

  task automatic t_once;
    @(negedge clk);
    slot = MY_SLOT; am = AM_OK; wr_n = 1'b0; sel = 4'b0110; wdata = 8'h77; strobe = 1'b1;
    pulses = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (cfg_cclk) pulses++;
      if (i == 2) begin wdata = 8'hFF; sel = 4'b1010; end
    end
    check("R7 one pulse per strobe", pulses[7:0], 8'd1);
    check("R7 data not rewritten", cfg_data, 8'h77);
    check("R7 ctrl untouched", {7'd0, cfg_cs_n}, 8'd1);
    strobe = 1'b0;
    repeat (3) @(negedge clk);
    access(MY_SLOT, AM_OK, 1'b0, 4'b0110, 8'h12);
    check("R7 next access taken", cfg_data, 8'h12);
  endtask

  task automatic t_badsel;
    access(MY_SLOT, AM_OK, 1'b0, 4'b0101, 8'hFF);
    check("R9 data kept", cfg_data, 8'h12);
    check("R9 cs kept", {7'd0, cfg_cs_n}, 8'd1);
    check("R9 prog kept", {7'd0, cfg_prog_n}, 8'd0);
    check("R9 no pulse", pulses[7:0], 8'd0);
  endtask

  task automatic t_reset_mid;
    access(MY_SLOT, AM_OK, 1'b0, 4'b1010, 8'h0E);
    @(negedge clk);
    sel = 4'b0110; wdata = 8'h99; strobe = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_powerup("R8 mid-cycle reset");
    @(negedge clk);
    strobe = 1'b0; rst_n = 1'b1;
    repeat (2) @(negedge clk);
    access(MY_SLOT, AM_OK, 1'b0, 4'b0000, 8'h08);
    check("R1 request resets to 1", {7'd0, cfg_prog_n}, 8'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_foreign;
    t_ctrl;
    t_data_disabled;
    t_enable;
    t_data_enabled;
    t_once;
    t_badsel;
    t_reset_mid;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule